// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. A host hands it one command at a time over a valid/ready port. The command carries a command code, an address and, for programming commands, a data word. The block then drives chip select, serial clock and serial data-in, and reads back the serial data-out line. Every frame starts with a fixed start bit, followed by a two-bit opcode and the address, most significant bit first. Commands that carry or return a data word use the long frame. The rest use the short one.

For a read, the block drops the single leading zero that the memory sends ahead of the data. It gathers the next sixteen bits into `rd_data` and pulses `done`. For programming commands (erase, write, erase-all, write-all) it drops chip select for the minimum low gap and then raises it again with the serial clock held low. It then samples data-out once per divider tick until the memory reports ready, and pulses `done`. If ready never comes, a bounded number of samples ends the wait with an error flag.

Command port rules: `cmd_ready` is high only while the block is idle. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The host must hold `cmd_op`, `cmd_addr` and `cmd_wdata` stable while `cmd_valid` is high and unaccepted. The completion side has no back-pressure: `done` is a single-cycle pulse the host must catch, and `rd_data` holds its value until the next read completes.

Top module: `mw_eeprom_host`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle, and chip select is low at that time. A command is taken on `cmd_valid && cmd_ready`. Chip select rises on the next cycle and `cmd_ready` stays low until the command has finished.
- R2: Each frame sends DI=1 as a start bit on the first rising serial clock, then two opcode bits, then ADDR_W address bits, MSB first. `cmd_op` codes: 0 read (opcode 10), 1 write (01), 2 erase (11), 3 write-enable, 4 write-disable, 5 erase-all, 6 write-all.
- R3: Codes 3 to 6 send opcode 00, with the top two address bits selecting the action: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all. The remaining address bits are zero. Code 7 acts as write-disable.
- R4: Read, write and write-all frames have 27 rising clock edges. The others have 11. Write data follows the address, MSB first. DI is low while read data is returned.
- R5: The serial clock idles low and pulses only while chip select is high. Each high and low phase inside a frame lasts DIV system clocks. DI changes only while the serial clock is low.
- R6: On a read, DO is sampled one half period after each rising edge. The sample after the last address bit is discarded. The following 16 samples form `rd_data`, MSB first, and `done` pulses for one cycle as the frame ends.
- R7: Between any two chip-select-high periods, chip select stays low for at least CSL_TICKS*DIV system clocks.
- R8: After a programming frame and the low gap, chip select rises with the clock low, and DO is sampled once per DIV system clocks. On the first high sample, chip select drops, `done` pulses for one cycle and `timeout_err` stays low.
- R9: If POLL_MAX consecutive samples are all low, chip select drops, `done` pulses and `timeout_err` rises. `timeout_err` clears when the next command is taken.
- R10: Write-enable and write-disable pulse `done` as their frame ends and start no polling window.
- R11: While reset is held: `cmd_ready`=1, chip select=0, serial clock=0, `done`=0, `timeout_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data word for write and write-all |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word read |
| timeout_err | output | 1 | Ready not seen within POLL_MAX samples |
| mw_cs | output | 1 | Chip select to the memory |
| mw_clk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The assertions assume that the command fields stay stable while a request waits. They also assume that `mw_do` has settled, already synchronised to `clk`, within one half period of a rising serial clock edge. The bench drives requests from a task that holds the fields until acceptance. It stands in for the memory with a model that changes DO only on serial clock edges or system clock edges, so DO is always settled well before the block samples it. The model's busy time is kept below the poll limit, except in the one case where DO is forced low on purpose to reach the timeout.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

  typedef enum logic [2:0] {
    CMD_READ      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_WREN      = 3'd3,
    CMD_WRDIS     = 3'd4,
    CMD_ERASE_ALL = 3'd5,
    CMD_WRITE_ALL = 3'd6
  } mw_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } mw_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_SPCL  = 2'b00;

  localparam logic [1:0] SEL_WREN      = 2'b11;
  localparam logic [1:0] SEL_WRDIS     = 2'b00;
  localparam logic [1:0] SEL_ERASE_ALL = 2'b10;
  localparam logic [1:0] SEL_WRITE_ALL = 2'b01;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample,
  output logic last
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign last = (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (sample && !last)  cnt <= cnt + 1'b1;
  end

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)) else $error("poll timer not cleared"); // R9
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_host_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int DIV       = 4,
  parameter int CSL_TICKS = 4,
  parameter int POLL_MAX  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout_err,
  output logic              mw_cs,
  output logic              mw_clk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int FRAME_SHORT = 1 + 2 + ADDR_W;
  localparam int FRAME_LONG  = FRAME_SHORT + DATA_W;
  localparam int CNT_W       = $clog2(FRAME_LONG + 1);
  localparam int GW          = $clog2(CSL_TICKS + 1);
  localparam int GAP_CYC     = CSL_TICKS * DIV;
  localparam int LW          = $clog2(GAP_CYC + 1);

  mw_state_e           state;
  logic                phase_hi;
  logic [FRAME_LONG-1:0] sh;
  logic [CNT_W-1:0]    bit_cnt;
  logic                is_long, is_read, is_prog;
  logic [DATA_W-2:0]   rd_sh;
  logic [DATA_W-1:0]   rd_next;
  logic [GW-1:0]       gap_cnt;
  logic                tick, poll_last, frame_end;

  logic [1:0]          f_opc;
  logic [ADDR_W-1:0]   f_adr;
  logic [DATA_W-1:0]   f_wd;
  logic                f_long, f_prog, f_read;

  mw_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .tick(tick)
  );

  mw_poll_timer #(.LIMIT(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(state != ST_POLL),
    .sample((state == ST_POLL) && tick), .last(poll_last)
  );

  // Frame fields for the offered command
  always_comb begin
    f_opc  = OPC_SPCL;
    f_adr  = cmd_addr;
    f_wd   = '0;
    f_long = 1'b0;
    f_prog = 1'b0;
    f_read = 1'b0;
    case (mw_cmd_e'(cmd_op))
      CMD_READ:      begin f_opc = OPC_READ;  f_long = 1'b1; f_read = 1'b1; end
      CMD_WRITE:     begin f_opc = OPC_WRITE; f_wd = cmd_wdata; f_long = 1'b1; f_prog = 1'b1; end
      CMD_ERASE:     begin f_opc = OPC_ERASE; f_prog = 1'b1; end
      CMD_WREN:      f_adr = {SEL_WREN, {(ADDR_W-2){1'b0}}};
      CMD_ERASE_ALL: begin f_adr = {SEL_ERASE_ALL, {(ADDR_W-2){1'b0}}}; f_prog = 1'b1; end
      CMD_WRITE_ALL: begin
        f_adr  = {SEL_WRITE_ALL, {(ADDR_W-2){1'b0}}};
        f_wd   = cmd_wdata;
        f_long = 1'b1;
        f_prog = 1'b1;
      end
      default:       f_adr = {SEL_WRDIS, {(ADDR_W-2){1'b0}}};
    endcase
  end

  assign cmd_ready = (state == ST_IDLE);
  assign mw_di     = (state == ST_SHIFT) && sh[FRAME_LONG-1];
  assign rd_next   = {rd_sh, mw_do};
  assign frame_end = (bit_cnt == (is_long ? CNT_W'(FRAME_LONG) : CNT_W'(FRAME_SHORT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      phase_hi    <= 1'b0;
      sh          <= '0;
      bit_cnt     <= '0;
      is_long     <= 1'b0;
      is_read     <= 1'b0;
      is_prog     <= 1'b0;
      rd_sh       <= '0;
      rd_data     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      gap_cnt     <= '0;
      mw_cs       <= 1'b0;
      mw_clk      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          sh          <= {1'b1, f_opc, f_adr, f_wd};
          is_long     <= f_long;
          is_read     <= f_read;
          is_prog     <= f_prog;
          bit_cnt     <= '0;
          phase_hi    <= 1'b0;
          timeout_err <= 1'b0;
          mw_cs       <= 1'b1;
          state       <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!phase_hi) begin
            mw_clk   <= 1'b1;
            phase_hi <= 1'b1;
            bit_cnt  <= bit_cnt + 1'b1;
          end else begin
            mw_clk   <= 1'b0;
            phase_hi <= 1'b0;
            sh       <= {sh[FRAME_LONG-2:0], 1'b0};
            if (is_read && (bit_cnt > CNT_W'(FRAME_SHORT)))
              rd_sh <= rd_next[DATA_W-2:0];
            if (frame_end) begin
              mw_cs   <= 1'b0;
              gap_cnt <= '0;
              state   <= ST_GAP;
              if (!is_prog) begin
                done <= 1'b1;
                if (is_read) rd_data <= rd_next;
              end
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_cnt == GW'(CSL_TICKS - 1)) begin
            gap_cnt <= '0;
            if (is_prog) begin
              mw_cs <= 1'b1;
              state <= ST_POLL;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_POLL: if (tick && (mw_do || poll_last)) begin
          mw_cs       <= 1'b0;
          done        <= 1'b1;
          is_prog     <= 1'b0;
          timeout_err <= !mw_do;
          state       <= ST_GAP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Chip-select low run length, for the gap check
  logic [LW-1:0] cs_low_cnt;
  logic          cs_was_high;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low_cnt  <= '0;
      cs_was_high <= 1'b0;
    end else begin
      cs_was_high <= cs_was_high | mw_cs;
      if (mw_cs)                            cs_low_cnt <= '0;
      else if (cs_low_cnt != LW'(GAP_CYC))  cs_low_cnt <= cs_low_cnt + 1'b1;
    end
  end

  AST_READY_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mw_cs) else $error("ready while selected"); // R1
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (mw_cs && !cmd_ready)) else $error("accept"); // R1
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mw_clk |-> mw_cs) else $error("clock outside frame"); // R5
  AST_DI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_clk) |-> $stable(mw_di)) else $error("DI moved at rising edge"); // R5
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mw_cs) && cs_was_high) |-> (cs_low_cnt == LW'(GAP_CYC))) else $error("short gap"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle"); // R8
  AST_TIMEOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (done && !mw_cs)) else $error("timeout without done"); // R9
endmodule

// File: tb/mw_eeprom_host_tb.sv
`timescale 1ns/1ps
module mw_eeprom_host_tb_top;
  import mw_host_pkg::*;

  localparam int DIV = 2, CSL = 3, PMAX = 20, BUSY = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready, done, timeout_err;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0, rd_data;
  logic mw_cs, mw_clk, mw_di, mw_do;

  mw_eeprom_host #(.ADDR_W(8), .DATA_W(16), .DIV(DIV), .CSL_TICKS(CSL), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
    .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_di(mw_di), .mw_do(mw_do)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model
  logic [15:0] mem [256];
  bit started = 1'b0, rd_act = 1'b0, do_q = 1'b0, we_en = 1'b0, stuck = 1'b0;
  bit kick = 1'b0, kick_seen = 1'b0;
  int ecnt = 0, last_cnt = 0, poll_cnt = 0, busy_cnt = 0;
  logic [26:0] fbits = '0, last_frame = '0;
  logic [15:0] rword = '0;

  always @(posedge mw_clk or negedge mw_cs) begin
    if (!mw_cs) begin
      if (started) begin
        last_frame = fbits;
        last_cnt   = ecnt;
        if (we_en) begin
          if (ecnt == 11 && fbits[9:8] == 2'b11) begin
            mem[fbits[7:0]] = 16'hFFFF; kick = ~kick;
          end else if (ecnt == 11 && fbits[9:8] == 2'b00 && fbits[7:6] == 2'b10) begin
            for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
            kick = ~kick;
          end else if (ecnt == 27 && fbits[25:24] == 2'b01) begin
            mem[fbits[23:16]] = fbits[15:0]; kick = ~kick;
          end else if (ecnt == 27 && fbits[25:24] == 2'b00 && fbits[23:22] == 2'b01) begin
            for (int i = 0; i < 256; i++) mem[i] = fbits[15:0];
            kick = ~kick;
          end
        end
      end else begin
        poll_cnt++;
      end
      started = 1'b0; ecnt = 0; rd_act = 1'b0;
    end else if (!started) begin
      if (mw_di) begin started = 1'b1; ecnt = 1; fbits = 27'd1; end
    end else begin
      ecnt++;
      fbits = {fbits[25:0], mw_di};
      if (ecnt == 11) begin
        if (fbits[9:8] == 2'b10) begin
          rword = mem[fbits[7:0]]; rd_act = 1'b1; do_q = 1'b0;
        end else if (fbits[9:8] == 2'b00) begin
          if (fbits[7:6] == 2'b11) we_en = 1'b1;
          else if (fbits[7:6] == 2'b00) we_en = 1'b0;
        end
      end else if (ecnt > 11 && rd_act) begin
        do_q  = rword[15];
        rword = {rword[14:0], 1'b0};
      end
    end
  end

  always @(posedge clk) begin
    if (kick != kick_seen) begin kick_seen <= kick; busy_cnt <= BUSY; end
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  assign mw_do = mw_cs & (rd_act ? do_q : ((busy_cnt == 0) && !stuck));

  // Pin monitors
  bit pclk = 1'b0, pdi = 1'b0, pcs = 1'b0, seen_hi = 1'b0;
  int run_len = 0, low_run = 0, min_low = 1000000, ph_viol = 0, di_viol = 0, edges = 0;
  always @(negedge clk) if (rst_n) begin
    if (mw_clk != pclk || (mw_cs && !pcs)) begin
      if (mw_clk != pclk) begin edges++; if (run_len != DIV) ph_viol++; end
      run_len = 1;
    end else run_len++;
    if (mw_clk && mw_di != pdi) di_viol++;
    if (!mw_cs) low_run++;
    else begin
      if (!pcs && seen_hi && low_run < min_low) min_low = low_run;
      low_run = 0; seen_hi = 1'b1;
    end
    pclk = mw_clk; pdi = mw_di; pcs = mw_cs;
  end

  function automatic logic [26:0] exp_frame(mw_cmd_e op, logic [7:0] a, logic [15:0] d);
    case (op)
      CMD_READ:      return {1'b1, 2'b10, a, 16'h0};
      CMD_WRITE:     return {1'b1, 2'b01, a, d};
      CMD_ERASE:     return {16'h0, 1'b1, 2'b11, a};
      CMD_WREN:      return {16'h0, 1'b1, 2'b00, 8'hC0};
      CMD_ERASE_ALL: return {16'h0, 1'b1, 2'b00, 8'h80};
      CMD_WRITE_ALL: return {1'b1, 2'b00, 8'h40, d};
      default:       return {16'h0, 1'b1, 2'b00, 8'h00};
    endcase
  endfunction

  function automatic int exp_cnt(mw_cmd_e op);
    return (op == CMD_READ || op == CMD_WRITE || op == CMD_WRITE_ALL) ? 27 : 11;
  endfunction

  function automatic logic [15:0] pat(int a);
    return {a[7:0], a[7:0]} ^ 16'h5A3C;
  endfunction

  task automatic issue(input mw_cmd_e op, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready && mw_cs, "R1 ready low after accept", {cmd_ready, mw_cs}, 2'b01);
    while (!done) @(negedge clk);
    chk(last_frame == exp_frame(op, a, d), "R2 frame bits", last_frame, exp_frame(op, a, d));
    chk(last_cnt == exp_cnt(op), "R4 clock count", last_cnt, exp_cnt(op));
  endtask

  task automatic prog(input mw_cmd_e op, input logic [7:0] a, input logic [15:0] d);
    int pc0;
    pc0 = poll_cnt;
    issue(op, a, d);
    chk(busy_cnt == 0 && poll_cnt > pc0 && !mw_cs, "R8 done after ready",
        {busy_cnt[15:0], 15'(poll_cnt - pc0), mw_cs}, 32'h0);
    chk(!timeout_err, "R8 no error", timeout_err, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
    issue(CMD_READ, a, 16'h0);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    int pc0;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !mw_cs && !mw_clk && !done && !timeout_err, "R11 reset state",
        {cmd_ready, mw_cs, mw_clk, done, timeout_err}, 5'b10000);
    rst_n = 1'b1;

    // Write-enable: short frame, no polling (R10, R3)
    pc0 = poll_cnt;
    issue(CMD_WREN, 8'h00, 16'h0);
    repeat (CSL * DIV + 4) @(negedge clk);
    chk(poll_cnt == pc0 && !mw_cs, "R10 no poll after enable", poll_cnt - pc0, 0);

    // Sweep every address: write, then read back (R2, R4, R6, R8)
    for (int a = 0; a < 256; a++) prog(CMD_WRITE, 8'(a), pat(a));
    for (int a = 0; a < 256; a++) rd(8'(a), pat(a), "R6 read data");

    // Erase and the special commands (R3)
    prog(CMD_ERASE, 8'h05, 16'h0);
    rd(8'h05, 16'hFFFF, "R3 erase one word");
    rd(8'h06, pat(6), "R6 neighbour kept");
    prog(CMD_WRITE_ALL, 8'h00, 16'h1234);
    rd(8'hB7, 16'h1234, "R3 write-all");
    prog(CMD_ERASE_ALL, 8'h00, 16'h0);
    rd(8'h00, 16'hFFFF, "R3 erase-all low");
    rd(8'hFF, 16'hFFFF, "R3 erase-all high");
    pc0 = poll_cnt;
    issue(CMD_WRDIS, 8'h00, 16'h0);
    repeat (CSL * DIV + 4) @(negedge clk);
    chk(poll_cnt == pc0, "R10 no poll after disable", poll_cnt - pc0, 0);

    // Timeout path (R9)
    stuck = 1'b1;
    issue(CMD_WRITE, 8'h10, 16'hBEEF);
    chk(timeout_err && !mw_cs, "R9 timeout flagged", {timeout_err, mw_cs}, 2'b10);
    stuck = 1'b0;
    issue(CMD_WREN, 8'h00, 16'h0);
    chk(!timeout_err, "R9 error cleared by next command", timeout_err, 0);

    repeat (20) @(negedge clk);
    chk(ph_viol == 0 && edges > 1000, "R5 half period", ph_viol, 0);
    chk(di_viol == 0, "R5 DI stable with clock high", di_viol, 0);
    chk(min_low >= CSL * DIV, "R7 chip select low gap", min_low, CSL * DIV);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL WATCHDOG actual=running expected=finished");
      finish_run();
    end
  end
endmodule